// File: doc/BRIEF.md
# Burst Transmit Serializer

This block assembles one outgoing radio burst and shifts it out one bit per clock. A strobe on `start_i` arms a burst. The block fetches the synchronisation field, the header field and the payload field from a shared nibble-wide memory, each from its own programmed start address. It sends them in that order, most significant bit of each nibble first. After the payload it sends a 4-bit check value computed over the payload bits, then sends the same check value a second time as a trailing guard field.

The launch point of the first bit can be pulled earlier by a programmable number of bit periods, to make up for delay in the analogue path. A mode bit can invert the transmitted data for modulators that need the opposite sense. The block captures all programming inputs when it accepts the strobe, so software may rewrite them for the next burst while the current one is still being sent.

Top module: `burst_tx_serializer`

## Requirements
- R1: During and straight after reset, `tx_active_o`, `tx_data_o` and `mem_rd_o` are all 0.
- R2: Count the clock edge that samples an accepted `start_i` as edge 0. The first burst bit and `tx_active_o` appear after edge 17 − `adv_i`. An advance of 0 gives nominal timing, and each advance unit moves the burst one bit period earlier.
- R3: The burst is sent one bit per clock in this order: S_NIBS synchronisation nibbles, A_NIBS header nibbles, B_NIBS payload nibbles, one check nibble, one guard nibble. Each nibble is sent bit 3 first. `tx_active_o` is high for exactly 4·(S_NIBS+A_NIBS+B_NIBS)+8 cycles.
- R4: Each memory field is read starting at its captured start address, and the address rises by one per nibble. Reads are issued in send order, one `mem_rd_o` pulse per nibble, never on two consecutive cycles. `mem_data_i` is sampled one cycle after the read pulse.
- R5: The check nibble is a CRC over the payload bits in send order. The register starts at 0 at each burst. For every bit, the feedback is register bit 3 XOR the data bit. The register shifts left with 0 entering, then XORs CRC_POLY (default 4'h3, x^4+x+1) when the feedback is 1.
- R6: The guard nibble is identical to the check nibble.
- R7: When `inv_i` is 1 at acceptance, every burst bit is inverted. While `tx_active_o` is 0, `tx_data_o` is 0.
- R8: A `start_i` pulse while a burst is pending or being sent is ignored and starts no later burst. Changes to addresses, `adv_i` and `inv_i` after acceptance do not affect the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start strobe |
| s_addr_i | input | ADDR_W | Synchronisation field start address |
| a_addr_i | input | ADDR_W | Header field start address |
| b_addr_i | input | ADDR_W | Payload field start address |
| adv_i | input | ADV_W | Start advance in bit periods |
| inv_i | input | 1 | Output inversion mode bit |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_data_i | input | 4 | Memory read data, valid one cycle after the strobe |
| tx_data_o | output | 1 | Serial transmit data |
| tx_active_o | output | 1 | High while burst bits are driven |

## Verification
The bench builds the block with 2 synchronisation nibbles, 3 header nibbles and 4 payload nibbles, with 8-bit addresses and the default 4-bit advance. A burst is then only 44 bits long, so every bit of every burst can be compared against a model. Every field boundary, including the switch from memory data to the CRC and from the CRC to its replay, is crossed within a few dozen cycles. The full advance range from 0 to 15 is still reachable, so both timing extremes are covered. Because the addresses are narrow, the bench can model the whole memory and check every read address.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} st_e;
  typedef enum logic [2:0] {FLD_S, FLD_A, FLD_B, FLD_X, FLD_Z} fld_e;
  localparam int unsigned NUM_MEM_FLD = 3;
endpackage

// File: rtl/burst_tx_crc.sv
module burst_tx_crc #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] POLY = 4'h3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o,
  output logic [W-1:0] crc_nxt_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = crc_q[W-1] ^ bit_i;

  always_comb begin
    crc_nxt_o = crc_q;
    if (clr_i)     crc_nxt_o = '0;
    else if (en_i) crc_nxt_o = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_nxt_o;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/burst_tx_addr_gen.sv
module burst_tx_addr_gen #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NFLD   = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [NFLD-1:0][ADDR_W-1:0] base_i,
  input  logic [NFLD-1:0]             inc_i,
  output logic [NFLD-1:0][ADDR_W-1:0] ptr_o
);
  for (genvar g = 0; g < NFLD; g++) begin : g_ptr
    logic [ADDR_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ptr_q <= '0;
      else if (load_i)   ptr_q <= base_i[g];
      else if (inc_i[g]) ptr_q <= ptr_q + 1'b1;
    end
    assign ptr_o[g] = ptr_q;
  end
endmodule

// File: rtl/burst_tx_sequencer.sv
module burst_tx_sequencer
  import burst_tx_pkg::*;
#(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned S_NIBS = 8,
  parameter int unsigned A_NIBS = 16,
  parameter int unsigned B_NIBS = 80,
  parameter int unsigned ADV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ADV_W-1:0] adv_i,
  input  logic             inv_i,
  input  logic [NIB_W-1:0] mem_data_i,
  input  logic [NIB_W-1:0] crc_q_i,
  input  logic [NIB_W-1:0] crc_nxt_i,
  output logic             load_o,
  output logic [2:0]       rd_sel_o,
  output logic             crc_en_o,
  output logic             crc_bit_o,
  output logic             tx_bit_o,
  output logic             active_o
);
  localparam int unsigned MAXN = (S_NIBS > A_NIBS) ?
                                 ((S_NIBS > B_NIBS) ? S_NIBS : B_NIBS) :
                                 ((A_NIBS > B_NIBS) ? A_NIBS : B_NIBS);
  localparam int unsigned NCW  = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam int unsigned BCW  = $clog2(NIB_W);
  localparam int unsigned WCW  = ADV_W + 1;
  localparam int unsigned LEAD = 1 << ADV_W;

  function automatic int fld_len(fld_e f);
    case (f)
      FLD_S:   return S_NIBS;
      FLD_A:   return A_NIBS;
      FLD_B:   return B_NIBS;
      default: return 1;
    endcase
  endfunction

  st_e              st_q;
  fld_e             fld_q, nxt_fld;
  logic [NCW-1:0]   nib_q;
  logic [BCW-1:0]   bit_q;
  logic [NIB_W-1:0] sh_q, load_val;
  logic [WCW-1:0]   wcnt_q;
  logic             inv_q;
  logic             last_bit, pre_bit, last_nib, burst_end, nxt_mem;

  assign last_bit  = bit_q == BCW'(NIB_W - 1);
  assign pre_bit   = bit_q == BCW'(NIB_W - 2);
  assign last_nib  = int'(nib_q) == fld_len(fld_q) - 1;
  assign nxt_fld   = last_nib ? fld_e'(fld_q + 3'd1) : fld_q;
  assign burst_end = (fld_q == FLD_Z) && last_bit;
  assign nxt_mem   = (nxt_fld == FLD_S) || (nxt_fld == FLD_A) || (nxt_fld == FLD_B);
  assign load_o    = (st_q == ST_IDLE) && start_i;

  always_comb begin
    rd_sel_o = 3'b000;
    if (st_q == ST_WAIT && wcnt_q == WCW'(1))
      rd_sel_o = 3'b001;
    else if (st_q == ST_SEND && pre_bit && fld_q != FLD_Z && nxt_mem)
      rd_sel_o = 3'b001 << nxt_fld;
  end

  always_comb begin
    case (nxt_fld)
      FLD_X:   load_val = crc_nxt_i;  // check value completes on this edge
      FLD_Z:   load_val = crc_q_i;    // replay held check value
      default: load_val = mem_data_i;
    endcase
  end

  assign crc_en_o  = (st_q == ST_SEND) && (fld_q == FLD_B);
  assign crc_bit_o = sh_q[NIB_W-1];
  assign active_o  = st_q == ST_SEND;
  assign tx_bit_o  = active_o & (sh_q[NIB_W-1] ^ inv_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fld_q  <= FLD_S;
      nib_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      wcnt_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_WAIT;
            wcnt_q <= WCW'(LEAD) - WCW'(adv_i);
            inv_q  <= inv_i;
          end
        end
        ST_WAIT: begin
          if (wcnt_q == '0) begin
            st_q  <= ST_SEND;
            sh_q  <= mem_data_i;
            fld_q <= FLD_S;
            nib_q <= '0;
            bit_q <= '0;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        ST_SEND: begin
          if (last_bit) begin
            if (burst_end) begin
              st_q <= ST_IDLE;
              sh_q <= '0;
            end else begin
              sh_q  <= load_val;
              fld_q <= nxt_fld;
              nib_q <= last_nib ? '0 : nib_q + 1'b1;
              bit_q <= '0;
            end
          end else begin
            sh_q  <= {sh_q[NIB_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_tx_serializer.sv
module burst_tx_serializer
  import burst_tx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned S_NIBS   = 8,
  parameter int unsigned A_NIBS   = 16,
  parameter int unsigned B_NIBS   = 80,
  parameter int unsigned ADV_W    = 4,
  parameter logic [3:0]  CRC_POLY = 4'h3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [ADV_W-1:0]  adv_i,
  input  logic              inv_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [3:0]        mem_data_i,
  output logic              tx_data_o,
  output logic              tx_active_o
);
  localparam int unsigned NIB_W = 4;

  logic                               load, crc_en, crc_bit;
  logic [2:0]                         rd_sel;
  logic [NIB_W-1:0]                   crc_q, crc_nxt;
  logic [NUM_MEM_FLD-1:0][ADDR_W-1:0] base, ptr;

  assign base = {b_addr_i, a_addr_i, s_addr_i};

  burst_tx_sequencer #(
    .NIB_W (NIB_W),
    .S_NIBS(S_NIBS),
    .A_NIBS(A_NIBS),
    .B_NIBS(B_NIBS),
    .ADV_W (ADV_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .adv_i     (adv_i),
    .inv_i     (inv_i),
    .mem_data_i(mem_data_i),
    .crc_q_i   (crc_q),
    .crc_nxt_i (crc_nxt),
    .load_o    (load),
    .rd_sel_o  (rd_sel),
    .crc_en_o  (crc_en),
    .crc_bit_o (crc_bit),
    .tx_bit_o  (tx_data_o),
    .active_o  (tx_active_o)
  );

  burst_tx_addr_gen #(
    .ADDR_W(ADDR_W),
    .NFLD  (NUM_MEM_FLD)
  ) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .base_i(base),
    .inc_i (rd_sel),
    .ptr_o (ptr)
  );

  burst_tx_crc #(
    .W   (NIB_W),
    .POLY(CRC_POLY)
  ) u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load),
    .en_i     (crc_en),
    .bit_i    (crc_bit),
    .crc_o    (crc_q),
    .crc_nxt_o(crc_nxt)
  );

  always_comb begin
    mem_addr_o = '0;
    for (int i = 0; i < NUM_MEM_FLD; i++)
      if (rd_sel[i]) mem_addr_o |= ptr[i];
  end

  assign mem_rd_o = |rd_sel;
endmodule

// File: rtl/burst_tx_checker.sv
module burst_tx_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_rd_o,
  input logic       tx_data_o,
  input logic       tx_active_o,
  input logic [2:0] rd_sel
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_quiet: assert (!tx_active_o && !tx_data_o && !mem_rd_o);
  end

  a_r2_fetch_before_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_active_o) |-> $past(mem_rd_o, 2));

  a_r4_no_back_to_back_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  a_r4_one_field_per_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel));

  a_r3_no_read_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_active_o) |-> !$past(mem_rd_o));

  a_r7_idle_output_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> !tx_data_o);
endmodule

bind burst_tx_serializer burst_tx_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_rd_o   (mem_rd_o),
  .tx_data_o  (tx_data_o),
  .tx_active_o(tx_active_o),
  .rd_sel     (rd_sel)
);

// File: tb/burst_tx_serializer_test.sv
`timescale 1ns/1ps
module burst_tx_serializer_test;
  localparam int SN = 2, AN = 3, BN = 4;
  localparam int NNIB = SN + AN + BN + 2;
  localparam int NBITS = 4 * NNIB;

  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, inv_i = 1'b0;
  logic [7:0] s_addr_i = '0, a_addr_i = '0, b_addr_i = '0;
  logic [3:0] adv_i = '0, mem_data_i;
  logic       mem_rd_o, tx_data_o, tx_active_o;
  logic [7:0] mem_addr_o;

  logic [3:0] mem [0:255];
  logic [7:0] rd_log [0:63];
  int         rd_total = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk_i = ~clk_i;

  burst_tx_serializer #(
    .ADDR_W(8), .S_NIBS(SN), .A_NIBS(AN), .B_NIBS(BN), .ADV_W(4), .CRC_POLY(4'h3)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .s_addr_i(s_addr_i), .a_addr_i(a_addr_i), .b_addr_i(b_addr_i),
    .adv_i(adv_i), .inv_i(inv_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .tx_data_o(tx_data_o), .tx_active_o(tx_active_o)
  );

  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      mem_data_i <= mem[mem_addr_o];
      rd_log[rd_total % 64] <= mem_addr_o;
      rd_total <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic run_burst(input logic [7:0] sa, input logic [7:0] aa, input logic [7:0] ba,
                           input logic [3:0] adv, input logic inv, input bit glitch);
    logic [3:0] nib [0:NNIB-1];
    logic [7:0] exp_addr [0:NNIB-1];
    logic [3:0] crc;
    int         k, base_rd;
    crc = '0;
    k = 0;
    for (int i = 0; i < SN; i++) begin exp_addr[k] = sa + 8'(i); nib[k] = mem[exp_addr[k]]; k++; end
    for (int i = 0; i < AN; i++) begin exp_addr[k] = aa + 8'(i); nib[k] = mem[exp_addr[k]]; k++; end
    for (int i = 0; i < BN; i++) begin
      exp_addr[k] = ba + 8'(i); nib[k] = mem[exp_addr[k]];
      for (int b = 3; b >= 0; b--)  // R5 model
        crc = {crc[2:0], 1'b0} ^ ((crc[3] ^ nib[k][b]) ? 4'h3 : 4'h0);
      k++;
    end
    nib[k] = crc; nib[k+1] = crc;  // R5 check, R6 guard replay
    base_rd = rd_total;

    @(negedge clk_i);
    s_addr_i = sa; a_addr_i = aa; b_addr_i = ba; adv_i = adv; inv_i = inv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (16 - int'(adv)) @(negedge clk_i);
    chk(tx_active_o == 1'b0, "R2 not yet active", int'(tx_active_o), 0);
    for (int i = 0; i < NBITS; i++) begin
      @(negedge clk_i);
      if (i == 0) chk(tx_active_o == 1'b1, "R2 launch", int'(tx_active_o), 1);
      chk(tx_data_o == (nib[i/4][3 - i%4] ^ inv), "R3 R7 bit", int'(tx_data_o),
          int'(nib[i/4][3 - i%4] ^ inv));
      if (glitch && i == 10) begin
        start_i = 1'b1; s_addr_i = 8'h99; a_addr_i = 8'h77; b_addr_i = 8'h55;
        adv_i = ~adv; inv_i = ~inv;
      end
      if (glitch && i == 11) start_i = 1'b0;
    end
    @(negedge clk_i);
    chk(tx_active_o == 1'b0, "R3 burst length", int'(tx_active_o), 0);
    chk(tx_data_o == 1'b0, "R7 idle low", int'(tx_data_o), 0);
    chk(rd_total - base_rd == SN + AN + BN, "R4 read count", rd_total - base_rd, SN + AN + BN);
    for (int i = 0; i < SN + AN + BN; i++)
      chk(rd_log[(base_rd + i) % 64] == exp_addr[i], "R4 read address",
          int'(rd_log[(base_rd + i) % 64]), int'(exp_addr[i]));
    if (glitch) begin
      for (int i = 0; i < 30; i++) begin
        @(negedge clk_i);
        chk(!tx_active_o && !mem_rd_o, "R8 ignored start", int'(tx_active_o), 0);
      end
    end
  endtask

  task automatic t_reset();
    chk(!tx_active_o && !tx_data_o && !mem_rd_o, "R1 during reset",
        int'({tx_active_o, tx_data_o, mem_rd_o}), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!tx_active_o && !tx_data_o && !mem_rd_o, "R1 after reset",
        int'({tx_active_o, tx_data_o, mem_rd_o}), 0);
  endtask

  task automatic t_nominal();        run_burst(8'h10, 8'h20, 8'h30, 4'd0, 1'b0, 1'b0); endtask
  task automatic t_advance_mid();    run_burst(8'h05, 8'h41, 8'h62, 4'd5, 1'b0, 1'b0); endtask
  task automatic t_advance_max_inv();run_burst(8'hFE, 8'h83, 8'h17, 4'd15, 1'b1, 1'b0); endtask
  task automatic t_zero_payload();   run_burst(8'h33, 8'h44, 8'hD0, 4'd2, 1'b1, 1'b0); endtask
  task automatic t_ignore_start();   run_burst(8'h21, 8'h52, 8'h74, 4'd7, 1'b0, 1'b1); endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i >= 8'hD0 && i < 8'hE0) ? 4'h0 : 4'((i * 5 + 3) & 15);
    #5;
    t_reset();
    t_nominal();
    t_advance_mid();
    t_advance_max_inv();
    t_zero_payload();
    t_ignore_start();
    t_nominal();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule